// File: doc/BRIEF.md
# Debug Matchpoint Comparator Bank

This block watches the processor's stream of memory and fetch events on behalf of a debug unit. It holds eight independent matchpoints. Each matchpoint has a control register and a 32-bit value register. Every cycle the processor may present one event, made of a kind and a 32-bit data word. Each matchpoint first checks that it is armed and that the event is of a kind it watches. It then compares the event data with its value register, signed or unsigned, using one of seven conditions.

The result is an 8-bit match vector, one bit per matchpoint. The vector is registered and appears one cycle after the event strobe. Logic further down the debug path can then chain, count or break on it. Software or a debug transport loads the registers through a plain write port.

Top module: `dmp_bank`

## Requirements
- R1: A synchronous active-low reset clears every control and value register and drives `match_o` to zero, so no matchpoint matches until it is configured.
- R2: A matchpoint whose control bit 0 (armed) is clear never matches, whatever the event.
- R3: Event kind codes are 1 fetch address, 2 load address, 3 store address, 4 load data and 5 store data. Kinds 0, 6 and 7 never match. Control bits [7:5] pick the watched kind: 1 to 5 match the event kind of the same code, 6 matches load or store address, and 7 matches load or store data.
- R4: A watched-kind code of 0 or a condition code of 0 never matches.
- R5: Control bits [3:1] hold the condition. Condition 1 (masked) matches when the bitwise AND of the event data and the value register is nonzero.
- R6: Condition 2 matches when the data equals the value, and condition 3 matches when they differ.
- R7: With control bit 4 clear, conditions 4, 5, 6 and 7 compare data against value unsigned, as less, less-or-equal, greater and greater-or-equal.
- R8: With control bit 4 set, the same four ordered conditions treat both operands as two's complement.
- R9: `match_o` is all zero in the cycle after `dbg_enable` was low or `cpu_in_reset` was high.
- R10: A match shows on `match_o` exactly one cycle after the edge that samples `ev_valid` high, for one cycle only. An edge with `ev_valid` low yields zero.
- R11: A write with `wr_addr[3]` clear loads control register `wr_addr[2:0]` from `wr_data[7:0]`. With `wr_addr[3]` set it loads value register `wr_addr[2:0]`. No other matchpoint changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_enable | input | 1 | Debug unit enabled |
| cpu_in_reset | input | 1 | Processor held in reset; suppresses matches |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Bit 3 selects value (1) or control (0); bits 2:0 select the matchpoint |
| wr_data | input | 32 | Register write data |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_data | input | 32 | Event address or data word |
| match_o | output | 8 | Registered match vector, one bit per matchpoint |

## Verification
The ordered tests use value registers near the sign boundary (0x80000000 and 0xFFFFFFFF). A design that ignores the signed bit, or applies it the wrong way round, then flips the less and greater bits against the expected vectors. Every watched-kind code is driven against every real event kind, plus the unused kinds. An error in the combined load-or-store decode or an unused kind leaking through shows up as a stray bit. The masked test uses disjoint and overlapping masks, so an equality or any-bit-set shortcut fails. Tests of value-only writes, disarmed matchpoints and the pulse width catch addressing that strikes the wrong register and an output that is held instead of pulsed.

// File: rtl/dmp_pkg.sv
// dmp_pkg: shared encodings for the matchpoint bank.
// Assumes the control register layout {watch[2:0], sgn, cond[2:0], armed}.
package dmp_pkg;

    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_IFETCH = 3'd1,
        EV_LDADR  = 3'd2,
        EV_STADR  = 3'd3,
        EV_LDDAT  = 3'd4,
        EV_STDAT  = 3'd5
    } ev_kind_e;

    typedef enum logic [2:0] {
        WT_NONE   = 3'd0,
        WT_IFETCH = 3'd1,
        WT_LDADR  = 3'd2,
        WT_STADR  = 3'd3,
        WT_LDDAT  = 3'd4,
        WT_STDAT  = 3'd5,
        WT_LSADR  = 3'd6,
        WT_LSDAT  = 3'd7
    } watch_e;

    typedef enum logic [2:0] {
        CC_OFF  = 3'd0,
        CC_MASK = 3'd1,
        CC_EQ   = 3'd2,
        CC_NE   = 3'd3,
        CC_LT   = 3'd4,
        CC_LE   = 3'd5,
        CC_GT   = 3'd6,
        CC_GE   = 3'd7
    } cond_e;

    typedef struct packed {
        watch_e watch;
        logic   sgn;
        cond_e  cond;
        logic   armed;
    } mp_ctrl_t;

    localparam int CTRL_W = $bits(mp_ctrl_t);

endpackage

// File: rtl/dmp_kind_filter.sv
// dmp_kind_filter: decides whether an event kind is one the matchpoint watches.
// Purely combinational; unknown event kinds never hit.
module dmp_kind_filter
    import dmp_pkg::*;
(
    input  watch_e     watch,
    input  logic [2:0] ev_kind,
    output logic       kind_hit
);

    // Map the watched kind onto the set of event kinds it accepts.
    always_comb begin
        unique case (watch)
            WT_IFETCH: kind_hit = (ev_kind == EV_IFETCH);
            WT_LDADR:  kind_hit = (ev_kind == EV_LDADR);
            WT_STADR:  kind_hit = (ev_kind == EV_STADR);
            WT_LDDAT:  kind_hit = (ev_kind == EV_LDDAT);
            WT_STDAT:  kind_hit = (ev_kind == EV_STDAT);
            WT_LSADR:  kind_hit = (ev_kind == EV_LDADR) || (ev_kind == EV_STADR);
            WT_LSDAT:  kind_hit = (ev_kind == EV_LDDAT) || (ev_kind == EV_STDAT);
            default:   kind_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmp_compare.sv
// dmp_compare: evaluates one condition between event data and a value.
// Combinational; sgn selects two's complement for the ordered conditions.
module dmp_compare
    import dmp_pkg::*;
#(
    parameter int DW = 32
) (
    input  cond_e          cond,
    input  logic           sgn,
    input  logic [DW-1:0]  data,
    input  logic [DW-1:0]  value,
    output logic           cmp_hit
);

    logic lt_u, lt_s, lt;
    logic eq;

    // Shared magnitude results; ordered conditions derive from lt and eq.
    always_comb begin
        lt_u = data < value;
        lt_s = $signed(data) < $signed(value);
        lt   = sgn ? lt_s : lt_u;
        eq   = (data == value);
    end

    // Select the condition result.
    always_comb begin
        unique case (cond)
            CC_MASK: cmp_hit = |(data & value);
            CC_EQ:   cmp_hit = eq;
            CC_NE:   cmp_hit = !eq;
            CC_LT:   cmp_hit = lt;
            CC_LE:   cmp_hit = lt || eq;
            CC_GT:   cmp_hit = !lt && !eq;
            CC_GE:   cmp_hit = !lt;
            default: cmp_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmp_matchpoint.sv
// dmp_matchpoint: one matchpoint, holding its control and value registers
// and producing an unregistered hit for the current event.
// Assumes writes are decoded by index IDX; bit IDX_W of the address picks value.
module dmp_matchpoint
    import dmp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 3,
    parameter int IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W:0]    wr_addr,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic [DW-1:0]     wr_val,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [DW-1:0]     ev_data,
    output logic              armed,
    output logic              hit
);

    mp_ctrl_t      ctrl_q;
    logic [DW-1:0] val_q;
    logic          sel;
    logic          kind_hit;
    logic          cmp_hit;

    assign sel = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(IDX));

    // Control register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (sel && !wr_addr[IDX_W])
            ctrl_q <= mp_ctrl_t'(wr_ctrl);
    end

    // Value register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (sel && wr_addr[IDX_W])
            val_q <= wr_val;
    end

    dmp_kind_filter u_kind (
        .watch    (ctrl_q.watch),
        .ev_kind  (ev_kind),
        .kind_hit (kind_hit)
    );

    dmp_compare #(.DW(DW)) u_cmp (
        .cond    (ctrl_q.cond),
        .sgn     (ctrl_q.sgn),
        .data    (ev_data),
        .value   (val_q),
        .cmp_hit (cmp_hit)
    );

    assign armed = ctrl_q.armed;
    assign hit   = ev_valid && ctrl_q.armed && kind_hit && cmp_hit;

endmodule

// File: rtl/dmp_bank.sv
// dmp_bank: bank of N_MP matchpoints with a registered match vector.
// Assumes one event per cycle; output is gated off when the debug unit is
// disabled or the processor is held in reset.
module dmp_bank
    import dmp_pkg::*;
#(
    parameter int N_MP = 8,
    parameter int DW   = 32,
    localparam int IDX_W = (N_MP > 1) ? $clog2(N_MP) : 1,
    localparam int AW    = IDX_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_enable,
    input  logic            cpu_in_reset,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            ev_valid,
    input  logic [2:0]      ev_kind,
    input  logic [DW-1:0]   ev_data,
    output logic [N_MP-1:0] match_o
);

    logic [N_MP-1:0] mp_hit;
    logic [N_MP-1:0] mp_present;
    logic [N_MP-1:0] match_q;

    for (genvar g = 0; g < N_MP; g++) begin : g_mp
        dmp_matchpoint #(.DW(DW), .IDX_W(IDX_W), .IDX(g)) u_mp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_ctrl  (wr_data[CTRL_W-1:0]),
            .wr_val   (wr_data),
            .ev_valid (ev_valid),
            .ev_kind  (ev_kind),
            .ev_data  (ev_data),
            .armed    (mp_present[g]),
            .hit      (mp_hit[g])
        );
    end

    // Register the gated hit vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= '0;
        else if (dbg_enable && !cpu_in_reset)
            match_q <= mp_hit;
        else
            match_q <= '0;
    end

    assign match_o = match_q;

endmodule

// dmp_bank_chk: temporal checks on the bank's ports and armed state.
module dmp_bank_chk #(
    parameter int N_MP = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dbg_enable,
    input logic            cpu_in_reset,
    input logic            ev_valid,
    input logic [2:0]      ev_kind,
    input logic [N_MP-1:0] mp_present,
    input logic [N_MP-1:0] match_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> match_o == '0); // R1

    for (genvar g = 0; g < N_MP; g++) begin : g_arm
        AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !mp_present[g] |=> !match_o[g]); // R2
    end

    AST_UNKNOWN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind == 3'd0 || ev_kind == 3'd6 || ev_kind == 3'd7)) |=> match_o == '0); // R3

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_enable || cpu_in_reset) |=> match_o == '0); // R9

    AST_NO_EVENT_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> match_o == '0); // R10

endmodule

bind dmp_bank dmp_bank_chk #(.N_MP(N_MP)) u_dmp_bank_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_enable   (dbg_enable),
    .cpu_in_reset (cpu_in_reset),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .mp_present   (mp_present),
    .match_o      (match_o)
);

// File: tb/dmp_bank_bench.sv
module dmp_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_enable = 1'b1;
    logic        cpu_in_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [31:0] ev_data = '0;
    logic [7:0]  match_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dmp_bank u_dmp_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_enable   (dbg_enable),
        .cpu_in_reset (cpu_in_reset),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ev_valid     (ev_valid),
        .ev_kind      (ev_kind),
        .ev_data      (ev_data),
        .match_o      (match_o)
    );

    // control word: [7:5] watch, [4] signed, [3:1] cond, [0] armed
    function automatic logic [31:0] ctl(input logic arm, input logic [2:0] cond,
                                        input logic sgn, input logic [2:0] watch);
        return {24'h0, watch, sgn, cond, arm};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: match_o=%02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [2:0] k, input logic [31:0] d, output logic [7:0] m);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_data = d;
        @(negedge clk);
        ev_valid = 1'b0;
        m = match_o;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) begin
            wr(4'(i), 32'h0);
            wr(4'(8 + i), 32'h0);
        end
    endtask

    task automatic t_reset();
        logic [7:0] m;
        chk("R1 after reset", match_o, 8'h00);
        fire(3'd1, 32'h0, m);
        chk("R1 unconfigured fetch", m, 8'h00);
        fire(3'd4, 32'hFFFF_FFFF, m);
        chk("R1 unconfigured load data", m, 8'h00);
    endtask

    task automatic t_present();
        logic [7:0] m;
        clear_all();
        wr(4'd9, 32'h10);
        wr(4'd1, ctl(1'b0, 3'd2, 1'b0, 3'd1));
        fire(3'd1, 32'h10, m);
        chk("R2 disarmed", m, 8'h00);
        wr(4'd1, ctl(1'b1, 3'd2, 1'b0, 3'd1));
        fire(3'd1, 32'h10, m);
        chk("R2 armed", m, 8'h02);
    endtask

    task automatic t_kinds();
        logic [7:0] m;
        clear_all();
        for (int i = 0; i < 8; i++) begin
            wr(4'(8 + i), 32'hFFFF_FFFF);
            wr(4'(i), ctl(1'b1, 3'd1, 1'b0, 3'(i + 1)));
        end
        wr(4'd7, ctl(1'b1, 3'd1, 1'b0, 3'd0));
        fire(3'd1, 32'h1, m); chk("R3 fetch", m, 8'h01);
        fire(3'd2, 32'h1, m); chk("R3 load addr", m, 8'h22);
        fire(3'd3, 32'h1, m); chk("R3 store addr", m, 8'h24);
        fire(3'd4, 32'h1, m); chk("R3 load data", m, 8'h48);
        fire(3'd5, 32'h1, m); chk("R3 store data", m, 8'h50);
        fire(3'd6, 32'h1, m); chk("R3 unknown kind 6", m, 8'h00);
        fire(3'd0, 32'h1, m); chk("R3 unknown kind 0", m, 8'h00);
        fire(3'd7, 32'h1, m); chk("R4 watch none / kind 7", m, 8'h00);
    endtask

    task automatic t_cond0();
        logic [7:0] m;
        clear_all();
        wr(4'd8, 32'h5);
        wr(4'd0, ctl(1'b1, 3'd0, 1'b0, 3'd1));
        fire(3'd1, 32'h5, m);
        chk("R4 condition 0", m, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] m;
        clear_all();
        wr(4'd8, 32'h0000_0F00);
        wr(4'd0, ctl(1'b1, 3'd1, 1'b0, 3'd1));
        fire(3'd1, 32'h0000_00F0, m); chk("R5 disjoint mask", m, 8'h00);
        fire(3'd1, 32'h0000_0100, m); chk("R5 one common bit", m, 8'h01);
    endtask

    task automatic t_eq();
        logic [7:0] m;
        clear_all();
        wr(4'd8, 32'h5); wr(4'd9, 32'h5);
        wr(4'd0, ctl(1'b1, 3'd2, 1'b0, 3'd3));
        wr(4'd1, ctl(1'b1, 3'd3, 1'b0, 3'd3));
        fire(3'd3, 32'h5, m); chk("R6 equal", m, 8'h01);
        fire(3'd3, 32'h6, m); chk("R6 not equal", m, 8'h02);
    endtask

    task automatic t_ordered(input logic sgn, input logic [31:0] v);
        clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(4'(8 + i), v);
            wr(4'(i), ctl(1'b1, 3'(4 + i), sgn, 3'd4));
        end
    endtask

    task automatic t_unsigned();
        logic [7:0] m;
        t_ordered(1'b0, 32'h8000_0000);
        fire(3'd4, 32'h7FFF_FFFF, m); chk("R7 unsigned below", m, 8'h03);
        fire(3'd4, 32'h8000_0000, m); chk("R7 unsigned equal", m, 8'h0A);
        fire(3'd4, 32'hFFFF_FFFF, m); chk("R7 unsigned above", m, 8'h0C);
    endtask

    task automatic t_signed();
        logic [7:0] m;
        t_ordered(1'b1, 32'hFFFF_FFFF);
        fire(3'd4, 32'h0000_0000, m); chk("R8 signed zero > -1", m, 8'h0C);
        fire(3'd4, 32'h8000_0000, m); chk("R8 signed min < -1", m, 8'h03);
        fire(3'd4, 32'hFFFF_FFFF, m); chk("R8 signed equal", m, 8'h0A);
    endtask

    task automatic t_gate();
        logic [7:0] m;
        clear_all();
        wr(4'd0, ctl(1'b1, 3'd2, 1'b0, 3'd1));
        dbg_enable = 1'b0;
        fire(3'd1, 32'h0, m); chk("R9 disabled", m, 8'h00);
        dbg_enable = 1'b1; cpu_in_reset = 1'b1;
        fire(3'd1, 32'h0, m); chk("R9 cpu reset", m, 8'h00);
        cpu_in_reset = 1'b0;
        fire(3'd1, 32'h0, m); chk("R9 enabled", m, 8'h01);
    endtask

    task automatic t_latency();
        clear_all();
        wr(4'd0, ctl(1'b1, 3'd2, 1'b0, 3'd1));
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 3'd1; ev_data = 32'h0;
        chk("R10 before edge", match_o, 8'h00);
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R10 one cycle later", match_o, 8'h01);
        @(negedge clk);
        chk("R10 pulse ends", match_o, 8'h00);
    endtask

    task automatic t_addr();
        logic [7:0] m;
        clear_all();
        wr(4'd8, 32'h7); wr(4'd10, 32'h7);
        wr(4'd0, ctl(1'b1, 3'd2, 1'b0, 3'd1));
        wr(4'd2, ctl(1'b1, 3'd2, 1'b0, 3'd1));
        fire(3'd1, 32'h7, m); chk("R11 both set", m, 8'h05);
        wr(4'd10, 32'h9);
        fire(3'd1, 32'h7, m); chk("R11 value write isolated", m, 8'h01);
        fire(3'd1, 32'h9, m); chk("R11 new value", m, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_present();
        t_kinds();
        t_cond0();
        t_masked();
        t_eq();
        t_unsigned();
        t_signed();
        t_gate();
        t_latency();
        t_addr();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #4_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule